// File: doc/BRIEF.md
# Command frame parser

This block watches an 8-bit byte stream, offered one byte per cycle under a valid qualifier, and picks out fixed-shape command frames. A frame opens with the byte 0x5B (`[`) and closes with 0x5D (`]`). Between the two markers it carries a length byte, a command code, three 32-bit argument words and a one-byte checksum. The bytes before the first marker and between frames are thrown away.

The parser checks the length byte, the checksum and the closing marker. When all three are correct, it presents the command code and the arguments for one cycle with a valid strobe. A checksum mismatch gives a one-cycle checksum-error pulse. A bad length byte or a missing closing marker gives a one-cycle framing-error pulse. The byte source upstream (a UART receiver, for example) and the logic that acts on the commands are not part of this block.

Top module: `cmd_frame_parser`

## Requirements
- R1: While reset is held, and in the cycle after it, `cmd_valid`, `sum_err` and `frame_err` are all low.
- R2: Each frame is sent in this order: 0x5B, a length byte, a command byte, 12 argument bytes, a checksum byte, then 0x5D. When a correct frame's 0x5D is accepted at a clock edge, `cmd_valid` is high for exactly the next cycle. In that cycle `cmd_id` holds the command byte.
- R3: Each argument word arrives most-significant byte first. The first word received appears on `cmd_args[31:0]`, the second on `[63:32]` and the third on `[95:64]`.
- R4: The checksum byte is chosen so that the 8-bit sum of the length, command, argument and checksum bytes is zero. If the sum is not zero when 0x5D arrives, `sum_err` pulses for one cycle and `cmd_valid` stays low.
- R5: The length byte must be 14. Any other value makes `frame_err` pulse in the cycle after that byte, and the parser goes back to searching for 0x5B.
- R6: An accepted 0x5B byte in any position, including the closing-marker position, restarts the frame from that byte. It raises no pulse, and the abandoned frame is never reported.
- R7: If the byte after the checksum is neither 0x5D nor 0x5B, `frame_err` pulses for one cycle and the frame is dropped.
- R8: Bytes received while the parser is searching for 0x5B produce no output pulse.
- R9: A byte presented while `in_valid` is low is ignored, even if it is 0x5B. Idle cycles may fall anywhere inside a frame.
- R10: In any cycle, at most one of `cmd_valid`, `sum_err` and `frame_err` is high, and none of them is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | `in_byte` carries a byte this cycle |
| in_byte | input | 8 | Byte from the stream |
| cmd_valid | output | 1 | One-cycle strobe: a correct frame was received |
| cmd_id | output | 8 | Command byte, valid while `cmd_valid` is high |
| cmd_args | output | 96 | The three argument words, the first word in the low bits |
| sum_err | output | 1 | One-cycle pulse: checksum mismatch |
| frame_err | output | 1 | One-cycle pulse: bad length byte or missing closing marker |

## Verification
Two functions can claim the same cycle: the restart on 0x5B and the test of the closing marker. The bench sends a complete frame body and checksum, then places 0x5B in the closing-marker position and continues with a second frame. It expects no framing error and exactly one dispatch, the one carrying the second frame's contents. A second pairing puts 0x5B on the bus with `in_valid` low in the middle of a frame. The bench expects that frame to be dispatched unchanged.

// File: rtl/cfp_pkg.sv
// Shared types for the command frame parser.
package cfp_pkg;
    typedef enum logic [2:0] {
        ST_HUNT,
        ST_COUNT,
        ST_ID,
        ST_ARGS,
        ST_CSUM,
        ST_TAIL
    } parse_state_t;
endpackage

// File: rtl/cfp_checksum.sv
// Running modulo-2^W byte sum.
// Assumes: load and add are never high together; load starts a new sum.
module cfp_checksum #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         add,
    input  logic [W-1:0] data,
    output logic         is_zero
);
    logic [W-1:0] acc;

    // Start the sum or add one byte to it.
    always_ff @(posedge clk) begin
        if (!rst_n)    acc <= '0;
        else if (load) acc <= data;
        else if (add)  acc <= acc + data;
    end

    assign is_zero = (acc == '0);
endmodule

// File: rtl/cfp_arg_store.sv
// Argument word registers. Each accepted byte is shifted into the word
// picked by word_sel, so bytes land most-significant first.
// Assumes: word_sel < NUM_ARGS whenever we is high.
module cfp_arg_store #(
    parameter int NUM_ARGS  = 3,
    parameter int ARG_BYTES = 4,
    localparam int ARG_W    = ARG_BYTES * 8,
    localparam int WSEL_W   = (NUM_ARGS > 1) ? $clog2(NUM_ARGS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [WSEL_W-1:0]         word_sel,
    input  logic [7:0]                data,
    output logic [NUM_ARGS*ARG_W-1:0] args_flat
);
    for (genvar w = 0; w < NUM_ARGS; w++) begin : g_word
        logic [ARG_W-1:0] word_q;

        // Shift one byte into this word when it is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (we && (word_sel == WSEL_W'(w)))
                word_q <= {word_q[ARG_W-9:0], data};
        end

        assign args_flat[w*ARG_W +: ARG_W] = word_q;
    end
endmodule

// File: rtl/cfp_sequencer.sv
// Frame state machine. It tracks the position of each byte in the frame,
// drives the datapath enables and raises the result pulses.
// Assumes: the checksum flag it receives already includes every byte up to
// and including the checksum byte by the time the closing marker arrives.
module cfp_sequencer import cfp_pkg::*; #(
    parameter int         NUM_ARGS   = 3,
    parameter int         ARG_BYTES  = 4,
    parameter logic [7:0] START_BYTE = 8'h5B,
    parameter logic [7:0] END_BYTE   = 8'h5D,
    localparam int ARG_TOTAL = NUM_ARGS * ARG_BYTES,
    localparam int IDX_W     = (ARG_TOTAL > 1) ? $clog2(ARG_TOTAL) : 1,
    localparam int WSEL_W    = (NUM_ARGS > 1) ? $clog2(NUM_ARGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic              sum_zero,
    output logic              sum_load,
    output logic              sum_add,
    output logic              id_load,
    output logic              arg_we,
    output logic [WSEL_W-1:0] arg_word,
    output logic              cmd_valid,
    output logic              sum_err,
    output logic              frame_err
);
    localparam logic [7:0]       FRAME_LEN = 8'(ARG_TOTAL + 2);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(ARG_TOTAL - 1);

    parse_state_t     state;
    logic [IDX_W-1:0] byte_idx;
    logic [IDX_W-1:0] word_full;
    logic             is_start;
    logic             body_byte;

    assign is_start  = in_valid && (in_byte == START_BYTE);
    assign body_byte = in_valid && !is_start;

    // Datapath enables, one per byte position.
    assign sum_load  = body_byte && (state == ST_COUNT);
    assign sum_add   = body_byte &&
                       (state == ST_ID || state == ST_ARGS || state == ST_CSUM);
    assign id_load   = body_byte && (state == ST_ID);
    assign arg_we    = body_byte && (state == ST_ARGS);
    assign word_full = byte_idx / IDX_W'(ARG_BYTES);
    assign arg_word  = word_full[WSEL_W-1:0];

    // Advance through the frame positions and raise the result pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_HUNT;
            byte_idx  <= '0;
            cmd_valid <= 1'b0;
            sum_err   <= 1'b0;
            frame_err <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            sum_err   <= 1'b0;
            frame_err <= 1'b0;
            if (is_start) begin
                state <= ST_COUNT;
            end else if (in_valid) begin
                case (state)
                    ST_HUNT:  state <= ST_HUNT;
                    ST_COUNT: begin
                        if (in_byte == FRAME_LEN) begin
                            state <= ST_ID;
                        end else begin
                            frame_err <= 1'b1;
                            state     <= ST_HUNT;
                        end
                    end
                    ST_ID: begin
                        byte_idx <= '0;
                        state    <= ST_ARGS;
                    end
                    ST_ARGS: begin
                        byte_idx <= byte_idx + 1'b1;
                        if (byte_idx == LAST_IDX) state <= ST_CSUM;
                    end
                    ST_CSUM:  state <= ST_TAIL;
                    ST_TAIL: begin
                        if (in_byte == END_BYTE) begin
                            cmd_valid <= sum_zero;
                            sum_err   <= !sum_zero;
                        end else begin
                            frame_err <= 1'b1;
                        end
                        state <= ST_HUNT;
                    end
                    default:  state <= ST_HUNT;
                endcase
            end
        end
    end
endmodule

// File: rtl/cmd_frame_parser.sv
// Command frame parser, top level. It wires together the sequencer, the
// checksum accumulator, the command byte register and the argument store.
// Assumes: one byte per cycle at most, qualified by in_valid.
module cmd_frame_parser #(
    parameter int         NUM_ARGS   = 3,
    parameter int         ARG_BYTES  = 4,
    parameter logic [7:0] START_BYTE = 8'h5B,
    parameter logic [7:0] END_BYTE   = 8'h5D,
    localparam int ARG_W  = ARG_BYTES * 8,
    localparam int WSEL_W = (NUM_ARGS > 1) ? $clog2(NUM_ARGS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [7:0]                in_byte,
    output logic                      cmd_valid,
    output logic [7:0]                cmd_id,
    output logic [NUM_ARGS*ARG_W-1:0] cmd_args,
    output logic                      sum_err,
    output logic                      frame_err
);
    logic              sum_load, sum_add, sum_zero;
    logic              id_load, arg_we;
    logic [WSEL_W-1:0] arg_word;

    cfp_sequencer #(
        .NUM_ARGS  (NUM_ARGS),
        .ARG_BYTES (ARG_BYTES),
        .START_BYTE(START_BYTE),
        .END_BYTE  (END_BYTE)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .sum_zero (sum_zero),
        .sum_load (sum_load),
        .sum_add  (sum_add),
        .id_load  (id_load),
        .arg_we   (arg_we),
        .arg_word (arg_word),
        .cmd_valid(cmd_valid),
        .sum_err  (sum_err),
        .frame_err(frame_err)
    );

    cfp_checksum #(.W(8)) u_sum (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (sum_load),
        .add    (sum_add),
        .data   (in_byte),
        .is_zero(sum_zero)
    );

    cfp_arg_store #(
        .NUM_ARGS (NUM_ARGS),
        .ARG_BYTES(ARG_BYTES)
    ) u_args (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (arg_we),
        .word_sel (arg_word),
        .data     (in_byte),
        .args_flat(cmd_args)
    );

    // Capture the command byte.
    always_ff @(posedge clk) begin
        if (!rst_n)       cmd_id <= '0;
        else if (id_load) cmd_id <= in_byte;
    end
endmodule

// File: rtl/cfp_checker.sv
// Protocol checker for the command frame parser, attached with bind.
module cfp_checker #(
    parameter logic [7:0] START_BYTE = 8'h5B,
    parameter logic [7:0] END_BYTE   = 8'h5D
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [7:0] in_byte,
    input logic       cmd_valid,
    input logic       sum_err,
    input logic       frame_err
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!cmd_valid && !sum_err && !frame_err));

    assert_dispatch_after_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($past(in_valid) && $past(in_byte) == END_BYTE));

    assert_sum_err_after_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sum_err |-> ($past(in_valid) && $past(in_byte) == END_BYTE));

    assert_start_no_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_byte == START_BYTE) |=> (!cmd_valid && !sum_err && !frame_err));

    assert_idle_no_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!cmd_valid && !sum_err && !frame_err));

    assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, sum_err, frame_err}));

    assert_single_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid || sum_err || frame_err) |=> !(cmd_valid || sum_err || frame_err));
endmodule

bind cmd_frame_parser cfp_checker #(
    .START_BYTE(START_BYTE),
    .END_BYTE  (END_BYTE)
) u_cfp_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .cmd_valid(cmd_valid),
    .sum_err  (sum_err),
    .frame_err(frame_err)
);

// File: tb/cmd_frame_parser_test.sv
`timescale 1ns/1ps
module cmd_frame_parser_test;
    localparam logic [7:0] SOF = 8'h5B;
    localparam logic [7:0] EOF = 8'h5D;
    localparam int K_OK = 0, K_SUM = 1, K_FRM = 2;

    typedef struct {
        int          kind;
        logic [7:0]  id;
        logic [95:0] args;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        cmd_valid, sum_err, frame_err;
    logic [7:0]  cmd_id;
    logic [95:0] cmd_args;

    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;
    exp_t expq[$];

    always #2 clk = ~clk;

    cmd_frame_parser uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .cmd_valid(cmd_valid), .cmd_id(cmd_id), .cmd_args(cmd_args),
        .sum_err(sum_err), .frame_err(frame_err)
    );

    // Monitor: compare each output pulse with the oldest expected event.
    always @(negedge clk) begin
        if (rst_n && (cmd_valid || sum_err || frame_err)) begin
            int act;
            checks++;
            act = cmd_valid ? K_OK : (sum_err ? K_SUM : K_FRM);
            if ((32'(cmd_valid) + 32'(sum_err) + 32'(frame_err)) > 1) begin
                failures++;
                $display("FAIL R10: outputs %b%b%b expected at most one high",
                         cmd_valid, sum_err, frame_err);
            end else if (expq.size() == 0) begin
                failures++;
                $display("FAIL R8: unexpected pulse kind %0d, expected none", act);
            end else begin
                exp_t e;
                e = expq.pop_front();
                if (act != e.kind) begin
                    failures++;
                    $display("FAIL %s: pulse kind %0d expected %0d", e.req, act, e.kind);
                end else if (act == K_OK && (cmd_id != e.id || cmd_args != e.args)) begin
                    failures++;
                    $display("FAIL %s: id=%h args=%h expected id=%h args=%h",
                             e.req, cmd_id, cmd_args, e.id, e.args);
                end
            end
        end
    end

    task automatic put(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_byte  = 8'h00;
    endtask

    task automatic idle(input int n, input logic [7:0] b);
        in_valid = 1'b0;
        in_byte  = b;
        repeat (n) @(posedge clk);
        #1;
        in_byte  = 8'h00;
    endtask

    function automatic logic [7:0] body_sum(input logic [7:0] id, input logic [95:0] args);
        logic [7:0] s;
        s = 8'd14 + id;
        for (int i = 0; i < 12; i++) s = s + args[i*8 +: 8];
        return s;
    endfunction

    // Send a frame. args holds the first word in [31:0]. A gap of idle cycles
    // with 0x5B on the bus (valid low) goes after the first argument byte.
    task automatic send_frame(input logic [7:0] id, input logic [95:0] args,
                              input logic [7:0] cnt, input bit bad_sum,
                              input logic [7:0] tail, input int gap, input string req);
        logic [7:0] cs;
        exp_t e;
        cs = 8'h00 - body_sum(id, args);
        if (bad_sum) cs = cs + 8'h01;
        e.id = id; e.args = args; e.req = req;
        put(SOF);
        if (cnt != 8'd14) begin
            e.kind = K_FRM;
            expq.push_back(e);
            put(cnt);
            return;
        end
        put(cnt);
        put(id);
        for (int w = 0; w < 3; w++)
            for (int b = 3; b >= 0; b--) begin
                put(args[w*32 + b*8 +: 8]);
                if (w == 0 && b == 3 && gap > 0) idle(gap, SOF);
            end
        put(cs);
        if (tail == EOF) begin
            e.kind = bad_sum ? K_SUM : K_OK;
            expq.push_back(e);
        end else if (tail != SOF) begin
            e.kind = K_FRM;
            expq.push_back(e);
        end
        put(tail);
    endtask

    task automatic drained(input string req);
        idle(4, 8'h00);
        checks++;
        if (expq.size() != 0) begin
            failures++;
            $display("FAIL %s: %0d expected pulses missing, expected 0", req, expq.size());
            expq.delete();
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (cmd_valid !== 1'b0 || sum_err !== 1'b0 || frame_err !== 1'b0) begin
            failures++;
            $display("FAIL R1: outputs %b%b%b during reset expected 000",
                     cmd_valid, sum_err, frame_err);
        end
        rst_n = 1'b1;
        idle(2, 8'h00);

        // R2 R3: basic frame, big-endian words, first word in low bits
        send_frame(8'h21, {32'h0A0B0C0D, 32'h11223344, 32'h01020304}, 8'd14, 0, EOF, 0, "R2");
        drained("R2");
        send_frame(8'h07, {32'h00000000, 32'hFFFFFFFF, 32'h80000001}, 8'd14, 0, EOF, 0, "R3");
        drained("R3");

        // R8: noise while searching, including a stray end marker
        put(8'h41); put(EOF); put(8'h00); put(8'h0E);
        drained("R8");

        // R4: checksum off by one
        send_frame(8'h33, {32'h12345678, 32'h9ABCDEF0, 32'h0F1E2D3C}, 8'd14, 1, EOF, 0, "R4");
        drained("R4");

        // R5: wrong length bytes
        send_frame(8'h01, 96'h0, 8'd13, 0, EOF, 0, "R5");
        send_frame(8'h01, 96'h0, 8'd15, 0, EOF, 0, "R5");
        drained("R5");

        // R6: restart after a partial frame
        put(SOF); put(8'd14); put(8'h44); put(8'h01); put(8'h02); put(8'h03);
        send_frame(8'h45, {32'hCAFEF00D, 32'h00C0FFEE, 32'hDEADBEEF}, 8'd14, 0, EOF, 0, "R6");
        drained("R6");

        // R6: start marker in the closing-marker slot, then a frame body
        send_frame(8'h50, {32'h01010101, 32'h02020202, 32'h03030303}, 8'd14, 0, SOF, 0, "R6");
        begin
            exp_t e;
            logic [95:0] a;
            logic [7:0] cs;
            a = {32'h77665544, 32'h33221100, 32'hA1B2C3D4};
            cs = 8'h00 - body_sum(8'h62, a);
            e.kind = K_OK; e.id = 8'h62; e.args = a; e.req = "R6";
            put(8'd14); put(8'h62);
            for (int w = 0; w < 3; w++)
                for (int b = 3; b >= 0; b--) put(a[w*32 + b*8 +: 8]);
            put(cs);
            expq.push_back(e);
            put(EOF);
        end
        drained("R6");

        // R7: missing closing marker
        send_frame(8'h70, {32'h10203040, 32'h50607080, 32'h90A0B0C0}, 8'd14, 0, 8'h00, 0, "R7");
        send_frame(8'h71, {32'h10203040, 32'h50607080, 32'h90A0B0C0}, 8'd14, 0, 8'h5C, 0, "R7");
        drained("R7");

        // R9: idle cycles with 0x5B on the bus inside a frame
        send_frame(8'h19, {32'h0C0D0E0F, 32'h08090A07, 32'h04050603}, 8'd14, 0, EOF, 5, "R9");
        drained("R9");

        // R10: back-to-back frames, good then bad checksum then good
        send_frame(8'hA0, {32'h11111111, 32'h22222222, 32'h33333333}, 8'd14, 0, EOF, 0, "R10");
        send_frame(8'hA1, {32'h44444444, 32'h55555555, 32'h66666666}, 8'd14, 1, EOF, 0, "R10");
        send_frame(8'hA2, {32'h77777777, 32'h88888888, 32'h99999999}, 8'd14, 0, EOF, 0, "R10");
        drained("R10");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule